// File: doc/BRIEF.md
# Host-Mode Inbound Address Window Decoder

This block sits at the inbound side of a bus bridge. For each inbound 32-bit address it decides which of three base-address windows the address falls into. It then returns the internal target address, an endian-policy flag and a hint that a read should be prefetched. All of this is registered, so results appear one cycle after the request.

Two direct-map windows are present only when the bridge runs as host. The low window is 1 GB wide and lands in the bottom 512 MB of internal memory. The high window is 2 GB wide and folds onto two separate 512 MB regions, 0x8000_0000 and 0xC000_0000. In both windows, address bit 29 keeps the same target but selects bit-lane matching instead of byte-lane matching. Each direct window has an enable bit in a configuration register. A third window covers 64 KB of the boot ROM and decodes in either mode once its base register's bit 0 is set.

Top module: `bar_win_dec`

## Requirements
- R1: In the first cycle after reset, every output is zero and both direct-window enables are set, so direct windows decode with no configuration.
- R2: Outputs are registered. `out_valid` equals `req_valid` from the previous cycle. A cycle without `req_valid` gives zero on every other output.
- R3: The low window hits when `req_addr[31:30]` equals `bar_lo_base[31:30]`. Its window code is 1 and its target is `{3'b000, req_addr[28:0]}`.
- R4: The high window hits when `req_addr[31]` equals `bar_hi_base[31]`. Its window code is 2 and its target is `{1'b1, req_addr[30], 1'b0, req_addr[28:0]}`, which places bit 30 clear at 0x8000_0000 and bit 30 set at 0xC000_0000.
- R5: On a direct-window hit, `out_bitlane` equals `req_addr[29]`, and the target does not depend on that bit.
- R6: The ROM window hits when `rom_bar[0]` is 1 and `req_addr[31:16]` equals `rom_bar[31:16]`. Its window code is 3, its target is `{16'h1FC0, req_addr[15:0]}` and `out_bitlane` is 0. The host-mode setting does not affect it.
- R7: When windows overlap, the ROM window wins over the low window, and the low window wins over the high window.
- R8: A configuration write to offset 0x40 loads the low-window enable from data bit 0 and the high-window enable from data bit 1. Writes to any other offset change nothing. A request in the same cycle as a write still sees the old enables.
- R9: When `host_mode` is 0, neither direct window hits.
- R10: `out_prefetch` is 1 exactly when there is a hit and the request is a read.
- R11: On a miss, `out_hit`, `out_win`, `out_addr`, `out_bitlane` and `out_prefetch` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host mode, 0 = device mode |
| bar_lo_base | input | 32 | Low direct-window base; bits 31:30 are compared |
| bar_hi_base | input | 32 | High direct-window base; bit 31 is compared |
| rom_bar | input | 32 | ROM window base in bits 31:16, enable in bit 0 |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_ofs | input | 8 | Configuration byte offset |
| cfg_wr_data | input | 32 | Configuration write data |
| req_valid | input | 1 | Inbound request valid |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 32 | Inbound bus address |
| out_valid | output | 1 | Registered request valid |
| out_hit | output | 1 | A window matched |
| out_win | output | 2 | 0 none, 1 low, 2 high, 3 ROM |
| out_addr | output | 32 | Translated internal address |
| out_bitlane | output | 1 | 1 = bit-lane matching, 0 = byte-lane matching |
| out_prefetch | output | 1 | Read hit that should be prefetched |

## Verification
Two functions can act in the same cycle: an enable update through a configuration write, and the decode of a request that the update would affect. The bench provokes this directly by clearing the low-window enable in the same cycle as a low-window read. It expects that request to hit under the old enable and the next one to miss. Random traffic also mixes writes to 0x40 and to other offsets with requests. A reference model updates its own enable copy only after it has computed the expectation for that cycle.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFS_W    = ADDR_W - 3;   // offset bits inside a 512 MB region
    localparam int LANE_BIT = ADDR_W - 3;   // bit 29: endian policy select
    localparam int SEL_BIT  = ADDR_W - 2;   // bit 30: high-window region select

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_LOW  = 2'd1,
        WIN_HIGH = 2'd2,
        WIN_ROM  = 2'd3
    } win_e;

    typedef struct packed {
        logic              hit;
        win_e              win;
        logic [ADDR_W-1:0] addr;
        logic              bitlane;
        logic              prefetch;
    } dec_res_t;

    localparam dec_res_t DEC_MISS = '{hit: 1'b0, win: WIN_NONE, addr: '0,
                                      bitlane: 1'b0, prefetch: 1'b0};

    // Low window: bottom 512 MB of memory
    function automatic logic [ADDR_W-1:0] map_low(input logic [ADDR_W-1:0] a);
        return {3'b000, a[OFS_W-1:0]};
    endfunction

    // High window: bit 30 picks 0x8000_0000 or 0xC000_0000 region
    function automatic logic [ADDR_W-1:0] map_high(input logic [ADDR_W-1:0] a);
        return {1'b1, a[SEL_BIT], 1'b0, a[OFS_W-1:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] map_rom(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] target,
                                                  input logic [ADDR_W-1:0] mask);
        return (target & ~mask) | (a & mask);
    endfunction

endpackage

// File: rtl/bar_cfg_reg.sv
module bar_cfg_reg #(
    parameter int          OFS_W   = 8,
    parameter int          N_EN    = 2,
    parameter logic [7:0]  CFG_OFS = 8'h40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [31:0]      wr_data,
    output logic [N_EN-1:0]  en_q
);
    localparam logic [OFS_W-1:0] MY_OFS = OFS_W'(CFG_OFS);

    logic hit_ofs;
    assign hit_ofs = wr_en && (wr_ofs == MY_OFS);

    always_ff @(posedge clk) begin
        if (rst)          en_q <= '1;
        else if (hit_ofs) en_q <= wr_data[N_EN-1:0];
    end
endmodule

// File: rtl/bar_win_match.sv
module bar_win_match #(
    parameter int ADDR_W  = 32,
    parameter int CMP_W   = 2,
    parameter bit BASE_EN = 1'b0   // 1: base bit 0 is the window enable
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              gate,
    output logic              match
);
    localparam int TOP = ADDR_W - 1;

    logic field_eq;
    assign field_eq = (addr[TOP -: CMP_W] == base[TOP -: CMP_W]);

    generate
        if (BASE_EN) begin : g_base_en
            assign match = gate && base[0] && field_eq;
        end else begin : g_plain
            assign match = gate && field_eq;
        end
    endgenerate
endmodule

// File: rtl/bar_win_dec.sv
module bar_win_dec
    import bar_dec_pkg::*;
#(
    parameter int          CFG_OFS_W  = 8,
    parameter logic [7:0]  CFG_EN_OFS = 8'h40,
    parameter int          ROM_LOG2   = 16,
    parameter logic [31:0] ROM_TARGET = 32'h1FC0_0000,
    parameter int          LOW_CMP_W  = 2,
    parameter int          HIGH_CMP_W = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_mode,
    input  logic [31:0]          bar_lo_base,
    input  logic [31:0]          bar_hi_base,
    input  logic [31:0]          rom_bar,
    input  logic                 cfg_wr_en,
    input  logic [CFG_OFS_W-1:0] cfg_wr_ofs,
    input  logic [31:0]          cfg_wr_data,
    input  logic                 req_valid,
    input  logic                 req_read,
    input  logic [31:0]          req_addr,
    output logic                 out_valid,
    output logic                 out_hit,
    output logic [1:0]           out_win,
    output logic [31:0]          out_addr,
    output logic                 out_bitlane,
    output logic                 out_prefetch
);
    localparam int          ROM_CMP_W = ADDR_W - ROM_LOG2;
    localparam logic [ADDR_W-1:0] ROM_MASK = (ADDR_W'(1) << ROM_LOG2) - ADDR_W'(1);
    localparam int          EN_LOW  = 0;
    localparam int          EN_HIGH = 1;
    localparam int          N_EN    = 2;

    logic [N_EN-1:0] en_q;
    logic            m_low, m_high, m_rom;
    logic            direct_ok;
    dec_res_t        res_d, res_q;
    logic            valid_q;

    bar_cfg_reg #(
        .OFS_W   (CFG_OFS_W),
        .N_EN    (N_EN),
        .CFG_OFS (CFG_EN_OFS)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_ofs  (cfg_wr_ofs),
        .wr_data (cfg_wr_data),
        .en_q    (en_q)
    );

    assign direct_ok = req_valid && host_mode;

    bar_win_match #(.ADDR_W(ADDR_W), .CMP_W(LOW_CMP_W), .BASE_EN(1'b0)) u_m_low (
        .addr (req_addr), .base (bar_lo_base),
        .gate (direct_ok && en_q[EN_LOW]), .match (m_low)
    );

    bar_win_match #(.ADDR_W(ADDR_W), .CMP_W(HIGH_CMP_W), .BASE_EN(1'b0)) u_m_high (
        .addr (req_addr), .base (bar_hi_base),
        .gate (direct_ok && en_q[EN_HIGH]), .match (m_high)
    );

    bar_win_match #(.ADDR_W(ADDR_W), .CMP_W(ROM_CMP_W), .BASE_EN(1'b1)) u_m_rom (
        .addr (req_addr), .base (rom_bar),
        .gate (req_valid), .match (m_rom)
    );

    // Fixed priority: ROM, then low, then high
    always_comb begin
        res_d = DEC_MISS;
        if (m_rom) begin
            res_d.hit  = 1'b1;
            res_d.win  = WIN_ROM;
            res_d.addr = map_rom(req_addr, ROM_TARGET, ROM_MASK);
        end else if (m_low) begin
            res_d.hit     = 1'b1;
            res_d.win     = WIN_LOW;
            res_d.addr    = map_low(req_addr);
            res_d.bitlane = req_addr[LANE_BIT];
        end else if (m_high) begin
            res_d.hit     = 1'b1;
            res_d.win     = WIN_HIGH;
            res_d.addr    = map_high(req_addr);
            res_d.bitlane = req_addr[LANE_BIT];
        end
        res_d.prefetch = res_d.hit && req_read;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= DEC_MISS;
            valid_q <= 1'b0;
        end else begin
            res_q   <= res_d;
            valid_q <= req_valid;
        end
    end

    assign out_valid    = valid_q;
    assign out_hit      = res_q.hit;
    assign out_win      = res_q.win;
    assign out_addr     = res_q.addr;
    assign out_bitlane  = res_q.bitlane;
    assign out_prefetch = res_q.prefetch;

endmodule

// File: rtl/bar_win_dec_chk.sv
module bar_win_dec_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_mode,
    input logic [31:0] rom_bar,
    input logic        req_valid,
    input logic        req_read,
    input logic [31:0] req_addr,
    input logic [1:0]  en_q,
    input logic        out_valid,
    input logic        out_hit,
    input logic [1:0]  out_win,
    input logic [31:0] out_addr,
    input logic        out_bitlane,
    input logic        out_prefetch
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && !out_hit)); // R2
    AST_LOW_ADDR: assert property (@(posedge clk) disable iff (rst)
        (out_hit && out_win == 2'd1) |-> out_addr[31:29] == 3'b000); // R3
    AST_LOW_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        req_valid && !en_q[0] |=> out_win != 2'd1); // R8
    AST_HIGH_ADDR: assert property (@(posedge clk) disable iff (rst)
        (out_hit && out_win == 2'd2) |-> (out_addr[31] && !out_addr[29])); // R4
    AST_LANE_FROM_BIT29: assert property (@(posedge clk) disable iff (rst)
        (out_hit && out_win != 2'd3) |-> out_bitlane == $past(req_addr[29])); // R5
    AST_ROM_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
        (out_win == 2'd3) |-> (!out_bitlane && $past(rom_bar[0]))); // R6
    AST_DEVICE_NO_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !host_mode) |=> (out_win == 2'd0 || out_win == 2'd3)); // R9
    AST_PREFETCH_READ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_prefetch == (out_hit && $past(req_read)))); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_hit |-> (out_win == 2'd0 && out_addr == 32'd0 && !out_bitlane && !out_prefetch)); // R11
endmodule

bind bar_win_dec bar_win_dec_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_mode    (host_mode),
    .rom_bar      (rom_bar),
    .req_valid    (req_valid),
    .req_read     (req_read),
    .req_addr     (req_addr),
    .en_q         (en_q),
    .out_valid    (out_valid),
    .out_hit      (out_hit),
    .out_win      (out_win),
    .out_addr     (out_addr),
    .out_bitlane  (out_bitlane),
    .out_prefetch (out_prefetch)
);

// File: tb/tb_bar_win_dec.sv
module tb_bar_win_dec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_mode = 1'b1;
    logic [31:0] bar_lo_base = 32'h4000_0000;
    logic [31:0] bar_hi_base = 32'h8000_0000;
    logic [31:0] rom_bar     = 32'h0001_0001;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_ofs = 8'h0;
    logic [31:0] cfg_wr_data = 32'h0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [31:0] req_addr = 32'h0;
    logic        out_valid, out_hit, out_bitlane, out_prefetch;
    logic [1:0]  out_win;
    logic [31:0] out_addr;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [1:0] en_m = 2'b11;

    always #10 clk = ~clk;   // 50 MHz

    bar_win_dec dut (
        .clk(clk), .rst(rst), .host_mode(host_mode),
        .bar_lo_base(bar_lo_base), .bar_hi_base(bar_hi_base), .rom_bar(rom_bar),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_win(out_win),
        .out_addr(out_addr), .out_bitlane(out_bitlane), .out_prefetch(out_prefetch)
    );

    // Reference: {valid, hit, win[1:0], addr[31:0], bitlane, prefetch}
    function automatic logic [37:0] model(input logic v, input logic rd,
                                          input logic [31:0] a, input logic host,
                                          input logic [1:0] en);
        logic [1:0]  w  = 2'd0;
        logic [31:0] t  = 32'd0;
        logic        bl = 1'b0;
        logic        h;
        if (v) begin
            if (rom_bar[0] && a[31:16] == rom_bar[31:16]) begin
                w = 2'd3; t = {16'h1FC0, a[15:0]};
            end else if (host && en[0] && a[31:30] == bar_lo_base[31:30]) begin
                w = 2'd1; t = {3'b000, a[28:0]}; bl = a[29];
            end else if (host && en[1] && a[31] == bar_hi_base[31]) begin
                w = 2'd2; t = {1'b1, a[30], 1'b0, a[28:0]}; bl = a[29];
            end
        end
        h = (w != 2'd0);
        return {v, h, w, t, bl, h && rd};
    endfunction

    task automatic compare(input logic [37:0] exp, input string tag);
        logic [37:0] act = {out_valid, out_hit, out_win, out_addr, out_bitlane, out_prefetch};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive one cycle, check at the next falling edge
    task automatic step(input logic v, input logic rd, input logic [31:0] a,
                        input logic cw, input logic [7:0] co, input logic [31:0] cd,
                        input string tag);
        logic [37:0] exp;
        req_valid = v; req_read = rd; req_addr = a;
        cfg_wr_en = cw; cfg_wr_ofs = co; cfg_wr_data = cd;
        exp = model(v, rd, a, host_mode, en_m);
        if (cw && co == 8'h40) en_m = cd[1:0];
        @(negedge clk);
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        compare(exp, tag);
    endtask

    function automatic string auto_tag(input logic [37:0] e);
        case (e[35:34])
            2'd1:    return "R3";
            2'd2:    return "R4";
            2'd3:    return "R6";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare(38'd0, "R1");                 // outputs cleared by reset

        // R1: enables start set, both direct windows decode
        step(1, 1, 32'h4123_4567, 0, 0, 0, "R1");
        step(1, 1, 32'h9123_4567, 0, 0, 0, "R1");
        // R3 / R5: low window, both lane policies
        step(1, 1, 32'h5FFF_FFF0, 0, 0, 0, "R3");
        step(1, 0, 32'h6000_0010, 0, 0, 0, "R5");
        // R4: high window, both regions
        step(1, 1, 32'h8000_0004, 0, 0, 0, "R4");
        step(1, 1, 32'hE555_0000, 0, 0, 0, "R4");
        // R6: ROM hit, then ROM disabled via bit 0
        step(1, 1, 32'h0001_ABCD, 0, 0, 0, "R6");
        rom_bar = 32'h0001_0000;
        step(1, 1, 32'h0001_ABCD, 0, 0, 0, "R6");
        // R7: ROM over low, low over high
        rom_bar = 32'h4003_0001;
        step(1, 1, 32'h4003_1234, 0, 0, 0, "R7");
        bar_lo_base = 32'h8000_0000;
        step(1, 1, 32'h9000_0000, 0, 0, 0, "R7");
        bar_lo_base = 32'h4000_0000;
        // R8: other offset ignored; same-cycle write sees old enables
        step(1, 1, 32'h4000_0100, 1, 8'h44, 32'h0, "R8");
        step(1, 1, 32'h4000_0200, 1, 8'h40, 32'h2, "R8");
        step(1, 1, 32'h4000_0300, 0, 0, 0, "R8");
        step(1, 1, 32'hA000_0300, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 8'h40, 32'h3, "R8");
        // R9: device mode blocks direct windows but not ROM
        host_mode = 1'b0;
        step(1, 1, 32'h4000_0000, 0, 0, 0, "R9");
        step(1, 1, 32'hC000_0000, 0, 0, 0, "R9");
        step(1, 1, 32'h4003_0040, 0, 0, 0, "R9");
        host_mode = 1'b1;
        // R10: write hit, no prefetch
        step(1, 0, 32'hB000_0000, 0, 0, 0, "R10");
        // R2: idle cycle with hitting address
        step(0, 1, 32'h4000_0000, 0, 0, 0, "R2");
        // R11: miss
        step(1, 1, 32'h0000_1000, 0, 0, 0, "R11");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a;
            logic [37:0] e;
            logic        cw;
            logic [7:0]  co;
            case ($urandom % 4)
                0: a = {bar_lo_base[31:30], 30'($urandom)};
                1: a = {bar_hi_base[31], 31'($urandom)};
                2: a = {rom_bar[31:16], 16'($urandom)};
                default: a = $urandom;
            endcase
            if ($urandom % 16 == 0) rom_bar = {16'($urandom), 15'd0, 1'($urandom)};
            if ($urandom % 16 == 0) bar_lo_base = $urandom;
            if ($urandom % 16 == 0) bar_hi_base = $urandom;
            if ($urandom % 10 == 0) host_mode = ~host_mode;
            cw = ($urandom % 8 == 0);
            co = ($urandom % 2 == 0) ? 8'h40 : 8'($urandom);
            e  = model(1'b1, 1'b0, a, host_mode, en_m);
            step(1'($urandom % 5 != 0), 1'($urandom), a, cw, co, $urandom, auto_tag(e));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule